// File: doc/BRIEF.md
# Scalar ALU with condition flag

A one-stage integer unit for the scalar side of a wide-issue shader pipeline. Each cycle it can accept one operation: an already decoded 4-bit opcode, two 64-bit operands and the present value of the one-bit condition flag. One clock edge later it returns a 64-bit result, a marker telling whether that result is 32 or 64 bits wide, and the value the flag must take next. The register file, operand fetch and instruction decode are outside the block.

The 32-bit group covers unsigned add, signed add, add with carry-in, multiply, left and right logical shifts, AND and unsigned bitfield extract. These operations read only the low half of each operand and return zeros in the upper half. The 64-bit group covers AND, AND with inverted second operand, OR, OR with inverted second operand, and NOR. Conditional select exists in both widths. Each operation has its own flag rule: it sets the flag from a carry, from an overflow or from a nonzero result, or it leaves the flag alone. The select operations read the flag instead of writing it.

An opcode the unit does not implement raises a one-cycle illegal-operation pulse instead of a result. The half width, the field position used by bitfield extract, and whether the multiplier is built are all parameters.

Top module: `scalar_alu`

## Requirements
- R1: All outputs are registered. An operation presented with `in_valid_i` high appears on the outputs after the next rising clock edge, with `res_valid_o` high. `res_wide_o` is high for opcodes 8 to 12 and 14. For every other legal opcode `res_o[63:32]` is zero. Opcode map: 0 unsigned add, 1 signed add, 2 add with carry, 3 multiply, 4 shift left, 5 shift right, 6 AND32, 7 bitfield extract, 8 AND64, 9 AND-with-inverted, 10 OR64, 11 OR-with-inverted, 12 NOR64, 13 select32, 14 select64.
- R2: Opcode 0 returns the low 32 bits of src0+src1. The flag becomes the carry out of bit 31.
- R3: Opcode 1 returns the same sum as opcode 0. The flag becomes 1 only when both operands have the same sign bit (bit 31) and the sum's sign bit differs from it.
- R4: Opcode 2 returns the low 32 bits of src0+src1+flag. The new flag is the carry of the first addition ORed with the carry of adding the old flag.
- R5: Opcode 3 returns the low 32 bits of the signed product of the two low halves. The flag is unchanged.
- R6: Opcodes 4 and 5 shift src0 left or right by src1[4:0] and fill with zeros. The flag becomes 1 exactly when the 32-bit result is nonzero.
- R7: Opcode 6 returns the bitwise AND of the low halves. The flag becomes 1 exactly when that result is nonzero.
- R8: Opcode 7 takes an offset from src1[4:0] and a width from src1[22:16]. It returns the field of src0 starting at that offset, right-justified and zero-extended. Width 0 returns 0. Bits above bit 31 of src0 read as 0, and widths of 32 or more take everything from the offset upward. The flag becomes 1 exactly when the result is nonzero.
- R9: Opcodes 8 to 12 compute src0&src1, src0&~src1, src0|src1, src0|~src1 and ~(src0|src1) over all 64 bits.
- R10: For opcodes 8 to 12 the flag becomes 1 exactly when either 32-bit half of the result is nonzero.
- R11: Opcodes 13 and 14 return src0 when the incoming flag is 1 and src1 when it is 0, over 32 or 64 bits. The flag is unchanged.
- R12: Opcode 15, and opcode 3 when the multiplier is not built, sets `illegal_o` for one cycle. In that cycle `res_valid_o` is low, the result is zero and the flag keeps its incoming value.
- R13: A cycle with `in_valid_i` low gives `res_valid_o` and `illegal_o` low, a zero result, and `flag_o` equal to `flag_i`.
- R14: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Decoded opcode |
| src0_i | input | 64 | First operand |
| src1_i | input | 64 | Second operand; for bitfield extract, packed offset and width |
| flag_i | input | 1 | Current condition flag |
| res_o | output | 64 | Result |
| res_valid_o | output | 1 | Result is valid |
| res_wide_o | output | 1 | Result is 64 bits wide |
| flag_o | output | 1 | Next condition flag |
| illegal_o | output | 1 | Unsupported opcode seen |

## Verification
The corner that is hardest to reach from the ports is add with carry when the incoming flag alone produces the carry. This happens when src0+src1 is exactly all ones in 32 bits and the flag is 1. The stimulus gets there by crossing every opcode with both flag values and with operand patterns that include all-ones, zero and one. A second hard corner is a bitfield extract whose field runs past bit 31. A dedicated sweep covers it: every offset from 0 to 31 against every width from 0 to 47 on one fixed source word.

// File: rtl/scalar_alu_pkg.sv
package scalar_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADDU  = 4'd0,
      OP_ADDS  = 4'd1,
      OP_ADDC  = 4'd2,
      OP_MUL   = 4'd3,
      OP_SHL   = 4'd4,
      OP_SHR   = 4'd5,
      OP_AND32 = 4'd6,
      OP_BFE   = 4'd7,
      OP_AND64 = 4'd8,
      OP_ANDN  = 4'd9,
      OP_OR64  = 4'd10,
      OP_ORN   = 4'd11,
      OP_NOR64 = 4'd12,
      OP_SEL32 = 4'd13,
      OP_SEL64 = 4'd14
   } salu_op_e;

   // function codes of the wide logic unit (low three opcode bits)
   localparam logic [2:0] LF_AND  = 3'd0;
   localparam logic [2:0] LF_ANDN = 3'd1;
   localparam logic [2:0] LF_OR   = 3'd2;
   localparam logic [2:0] LF_ORN  = 3'd3;
   localparam logic [2:0] LF_NOR  = 3'd4;

endpackage

// File: rtl/salu_arith.sv
// Adders and multiplier on one half-width word.
module salu_arith #(
   parameter int unsigned W       = 32,
   parameter bit          HAS_MUL = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o,
   output logic [W-1:0] sumc_o,
   output logic         carryc_o,
   output logic [W-1:0] mul_o
);

   logic [W:0] first_add;
   logic [W:0] second_add;

   assign first_add  = {1'b0, a_i} + {1'b0, b_i};
   assign second_add = {1'b0, first_add[W-1:0]} + {{W{1'b0}}, cin_i};

   assign sum_o    = first_add[W-1:0];
   assign carry_o  = first_add[W];
   assign ovf_o    = (a_i[W-1] == b_i[W-1]) && (first_add[W-1] != a_i[W-1]);
   assign sumc_o   = second_add[W-1:0];
   assign carryc_o = first_add[W] | second_add[W];

   generate
      if (HAS_MUL) begin : g_mul
         logic signed [2*W-1:0] a_ext;
         logic signed [2*W-1:0] b_ext;
         logic signed [2*W-1:0] prod;
         logic        [W-1:0]   prod_high_unused;
         assign a_ext = {{W{a_i[W-1]}}, a_i};
         assign b_ext = {{W{b_i[W-1]}}, b_i};
         assign prod  = a_ext * b_ext;
         assign mul_o = prod[W-1:0];
         assign prod_high_unused = prod[2*W-1:W];
      end else begin : g_no_mul
         assign mul_o = '0;
      end
   endgenerate

endmodule

// File: rtl/salu_shift_bfe.sv
// Logical shifts and unsigned bitfield extract on one half-width word.
module salu_shift_bfe #(
   parameter int unsigned W       = 32,
   parameter int unsigned WID_LSB = 16
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] shl_o,
   output logic [W-1:0] shr_o,
   output logic [W-1:0] bfe_o
);

   localparam int unsigned SHW = $clog2(W);
   localparam int unsigned WB  = SHW + 2;

   logic [SHW-1:0] amount;
   logic [WB-1:0]  field_w;
   logic [W-1:0]   shifted;
   logic [W-1:0]   field_mask;
   logic [W-1:0]   all_ones;
   logic           b_unused_bits;

   assign amount   = b_i[SHW-1:0];
   assign field_w  = b_i[WID_LSB +: WB];
   assign all_ones = '1;

   assign shl_o   = a_i << amount;
   assign shr_o   = a_i >> amount;
   assign shifted = shr_o;

   always_comb begin
      if (32'(field_w) >= W) field_mask = all_ones;
      else                   field_mask = ~(all_ones << field_w);
   end

   assign bfe_o = shifted & field_mask;

   generate
      if (WID_LSB + WB < W) begin : g_tail
         assign b_unused_bits = ^{b_i[W-1:WID_LSB+WB], b_i[WID_LSB-1:SHW]};
      end else begin : g_no_tail
         assign b_unused_bits = ^b_i[WID_LSB-1:SHW];
      end
   endgenerate

endmodule

// File: rtl/salu_logic_wide.sv
// Double-width bitwise unit, evaluated per half-word, with nonzero detect.
module salu_logic_wide #(
   parameter int unsigned W = 32
) (
   input  logic [2*W-1:0] a_i,
   input  logic [2*W-1:0] b_i,
   input  logic [2:0]     fn_i,
   output logic [2*W-1:0] y_o,
   output logic           nz_o
);
   import scalar_alu_pkg::*;

   localparam int unsigned NHALF = 2;

   logic [NHALF-1:0] half_nz;

   generate
      for (genvar h = 0; h < NHALF; h++) begin : g_half
         logic [W-1:0] x;
         logic [W-1:0] y;
         logic [W-1:0] z;
         assign x = a_i[h*W +: W];
         assign y = b_i[h*W +: W];
         always_comb begin
            case (fn_i)
               LF_AND:  z = x & y;
               LF_ANDN: z = x & ~y;
               LF_OR:   z = x | y;
               LF_ORN:  z = x | ~y;
               LF_NOR:  z = ~(x | y);
               default: z = '0;
            endcase
         end
         assign y_o[h*W +: W] = z;
         assign half_nz[h]    = |z;
      end
   endgenerate

   assign nz_o = |half_nz;

endmodule

// File: rtl/scalar_alu.sv
module scalar_alu #(
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned BFE_WID_LSB = 16,
   parameter bit          HAS_MUL     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid_i,
   input  logic [3:0]            op_i,
   input  logic [2*WORD_W-1:0]   src0_i,
   input  logic [2*WORD_W-1:0]   src1_i,
   input  logic                  flag_i,
   output logic [2*WORD_W-1:0]   res_o,
   output logic                  res_valid_o,
   output logic                  res_wide_o,
   output logic                  flag_o,
   output logic                  illegal_o
);
   import scalar_alu_pkg::*;

   localparam int unsigned DW  = 2 * WORD_W;
   localparam int unsigned SHW = $clog2(WORD_W);
   localparam int unsigned WB  = SHW + 2;
   localparam bit CFG_OK = (WORD_W >= 8) && ((WORD_W & (WORD_W - 1)) == 0)
                           && (BFE_WID_LSB >= SHW) && (BFE_WID_LSB + WB <= WORD_W);

   generate
      if (!CFG_OK) begin : g_cfg_bad
         $error("scalar_alu: WORD_W must be a power of two >= 8 and the extract width field must fit");
      end
   endgenerate

   // ---- operand split ----
   logic [WORD_W-1:0] a_lo;
   logic [WORD_W-1:0] b_lo;
   assign a_lo = src0_i[WORD_W-1:0];
   assign b_lo = src1_i[WORD_W-1:0];

   // ---- units ----
   logic [WORD_W-1:0] sum_w, sumc_w, mul_w, shl_w, shr_w, bfe_w;
   logic              carry_w, ovf_w, carryc_w;
   logic [DW-1:0]     logic_w;
   logic              logic_nz;

   salu_arith #(.W(WORD_W), .HAS_MUL(HAS_MUL)) arith_i (
      .a_i      (a_lo),
      .b_i      (b_lo),
      .cin_i    (flag_i),
      .sum_o    (sum_w),
      .carry_o  (carry_w),
      .ovf_o    (ovf_w),
      .sumc_o   (sumc_w),
      .carryc_o (carryc_w),
      .mul_o    (mul_w)
   );

   salu_shift_bfe #(.W(WORD_W), .WID_LSB(BFE_WID_LSB)) shift_i (
      .a_i   (a_lo),
      .b_i   (b_lo),
      .shl_o (shl_w),
      .shr_o (shr_w),
      .bfe_o (bfe_w)
   );

   salu_logic_wide #(.W(WORD_W)) logic_i (
      .a_i  (src0_i),
      .b_i  (src1_i),
      .fn_i (op_i[2:0]),
      .y_o  (logic_w),
      .nz_o (logic_nz)
   );

   // ---- result and flag selection ----
   logic [WORD_W-1:0] narrow_res;
   logic [DW-1:0]     next_res;
   logic              next_flag;
   logic              next_wide;
   logic              legal;
   logic              narrow_nz;

   always_comb begin
      narrow_res = '0;
      case (op_i)
         OP_ADDU, OP_ADDS: narrow_res = sum_w;
         OP_ADDC:          narrow_res = sumc_w;
         OP_MUL:           narrow_res = mul_w;
         OP_SHL:           narrow_res = shl_w;
         OP_SHR:           narrow_res = shr_w;
         OP_AND32:         narrow_res = a_lo & b_lo;
         OP_BFE:           narrow_res = bfe_w;
         OP_SEL32:         narrow_res = flag_i ? a_lo : b_lo;
         default:          narrow_res = '0;
      endcase
   end

   assign narrow_nz = |narrow_res;

   always_comb begin
      next_res  = {{WORD_W{1'b0}}, narrow_res};
      next_flag = flag_i;
      next_wide = 1'b0;
      legal     = 1'b1;
      case (op_i)
         OP_ADDU:  next_flag = carry_w;
         OP_ADDS:  next_flag = ovf_w;
         OP_ADDC:  next_flag = carryc_w;
         OP_MUL:   legal     = HAS_MUL;
         OP_SHL, OP_SHR, OP_AND32, OP_BFE:
                   next_flag = narrow_nz;
         OP_AND64, OP_ANDN, OP_OR64, OP_ORN, OP_NOR64: begin
            next_res  = logic_w;
            next_flag = logic_nz;
            next_wide = 1'b1;
         end
         OP_SEL32: next_flag = flag_i;
         OP_SEL64: begin
            next_res  = flag_i ? src0_i : src1_i;
            next_wide = 1'b1;
         end
         default:  legal = 1'b0;
      endcase
      if (!legal) begin
         next_res  = '0;
         next_flag = flag_i;
         next_wide = 1'b0;
      end
   end

   // ---- output stage ----
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_o       <= '0;
         res_valid_o <= 1'b0;
         res_wide_o  <= 1'b0;
         flag_o      <= 1'b0;
         illegal_o   <= 1'b0;
      end else if (in_valid_i) begin
         res_o       <= next_res;
         res_valid_o <= legal;
         res_wide_o  <= next_wide;
         flag_o      <= next_flag;
         illegal_o   <= ~legal;
      end else begin
         res_o       <= '0;
         res_valid_o <= 1'b0;
         res_wide_o  <= 1'b0;
         flag_o      <= flag_i;
         illegal_o   <= 1'b0;
      end
   end

endmodule

// File: rtl/scalar_alu_chk.sv
module scalar_alu_chk #(
   parameter int unsigned WORD_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid_i,
   input logic [3:0]          op_i,
   input logic [2*WORD_W-1:0] src0_i,
   input logic [2*WORD_W-1:0] src1_i,
   input logic                flag_i,
   input logic [2*WORD_W-1:0] res_o,
   input logic                res_valid_o,
   input logic                res_wide_o,
   input logic                flag_o,
   input logic                illegal_o
);
   import scalar_alu_pkg::*;

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(in_valid_i) |-> !res_valid_o && !illegal_o);

   p_narrow_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && !res_wide_o |-> res_o[2*WORD_W-1:WORD_W] == '0);

   p_addu_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && $past(op_i) == OP_ADDU |->
         {flag_o, res_o[WORD_W-1:0]} ==
         ({1'b0, $past(src0_i[WORD_W-1:0])} + {1'b0, $past(src1_i[WORD_W-1:0])}));

   p_mul_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && $past(op_i) == OP_MUL |-> flag_o == $past(flag_i));

   p_wide_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && res_wide_o && $past(op_i) != OP_SEL64 |-> flag_o == (res_o != '0));

   p_select_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && ($past(op_i) == OP_SEL32 || $past(op_i) == OP_SEL64)
         |-> flag_o == $past(flag_i));

   p_illegal_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid_o && illegal_o));

   p_illegal_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> res_o == '0 && flag_o == $past(flag_i));

   p_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !res_valid_o && !illegal_o |-> res_o == '0 && flag_o == $past(flag_i));

endmodule

bind scalar_alu scalar_alu_chk #(.WORD_W(WORD_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid_i  (in_valid_i),
   .op_i        (op_i),
   .src0_i      (src0_i),
   .src1_i      (src1_i),
   .flag_i      (flag_i),
   .res_o       (res_o),
   .res_valid_o (res_valid_o),
   .res_wide_o  (res_wide_o),
   .flag_o      (flag_o),
   .illegal_o   (illegal_o)
);

// File: tb/scalar_alu_tb_top.sv
`timescale 1ns/1ps
module scalar_alu_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [63:0] src0_i = '0;
   logic [63:0] src1_i = '0;
   logic        flag_i = 1'b0;
   logic [63:0] res_o;
   logic        res_valid_o, res_wide_o, flag_o, illegal_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   scalar_alu dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .op_i(op_i),
      .src0_i(src0_i), .src1_i(src1_i), .flag_i(flag_i), .res_o(res_o),
      .res_valid_o(res_valid_o), .res_wide_o(res_wide_o), .flag_o(flag_o),
      .illegal_o(illegal_o)
   );

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] pat(input int i);
      case (i)
         0:  return 64'h0000_0000_0000_0000;
         1:  return 64'hFFFF_FFFF_FFFF_FFFF;
         2:  return 64'h0000_0000_0000_0001;
         3:  return 64'h8000_0000_8000_0000;
         4:  return 64'h7FFF_FFFF_7FFF_FFFF;
         5:  return 64'hFFFF_FFFF_0000_0000;
         6:  return 64'h0000_0000_FFFF_FFFF;
         7:  return 64'h1234_5678_9ABC_DEF0;
         8:  return 64'h0000_001F_0000_001F;
         9:  return 64'h0000_0020_0000_0021;
         10: return 64'h000A_0004_0005_0008;
         default: return 64'hDEAD_BEEF_0013_0C07;
      endcase
   endfunction

   // expected {illegal, valid, wide, flag, result[63:0]}
   function automatic logic [67:0] model(input logic [3:0] op, input logic [63:0] a,
                                         input logic [63:0] b, input logic f);
      logic [31:0] a0, b0, r32;
      logic [63:0] r;
      logic [32:0] s;
      logic signed [63:0] p;
      logic        fo, w, il;
      int          off, wd;
      a0 = a[31:0]; b0 = b[31:0];
      r = '0; r32 = '0; fo = f; w = 1'b0; il = 1'b0;
      case (op)
         4'd0: begin s = {1'b0, a0} + {1'b0, b0}; r32 = s[31:0]; fo = s[32]; end
         4'd1: begin s = {1'b0, a0} + {1'b0, b0}; r32 = s[31:0];
                     fo = (a0[31] == b0[31]) && (s[31] != a0[31]); end
         4'd2: begin s = {1'b0, a0} + {1'b0, b0} + {32'd0, f}; r32 = s[31:0]; fo = s[32]; end
         4'd3: begin p = $signed({{32{a0[31]}}, a0}) * $signed({{32{b0[31]}}, b0}); r32 = p[31:0]; end
         4'd4: begin r32 = a0 << b0[4:0]; fo = (r32 != 0); end
         4'd5: begin r32 = a0 >> b0[4:0]; fo = (r32 != 0); end
         4'd6: begin r32 = a0 & b0; fo = (r32 != 0); end
         4'd7: begin
            off = int'(b0[4:0]); wd = int'(b0[22:16]);
            for (int i = 0; i < 32; i++)
               r32[i] = (i < wd) && (off + i < 32) ? a0[off + i] : 1'b0;
            fo = (r32 != 0);
         end
         4'd8:  begin r = a & b;    w = 1'b1; end
         4'd9:  begin r = a & ~b;   w = 1'b1; end
         4'd10: begin r = a | b;    w = 1'b1; end
         4'd11: begin r = a | ~b;   w = 1'b1; end
         4'd12: begin r = ~(a | b); w = 1'b1; end
         4'd13: r32 = f ? a0 : b0;
         4'd14: begin r = f ? a : b; w = 1'b1; end
         default: il = 1'b1;
      endcase
      if (op >= 4'd8 && op <= 4'd12) fo = (r[63:32] != 0) || (r[31:0] != 0);
      else if (op != 4'd14) r = {32'd0, r32};
      if (il) r = '0;
      return {il, ~il, w, fo, r};
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0: return "R2";
         4'd1: return "R3";
         4'd2: return "R4";
         4'd3: return "R5";
         4'd4, 4'd5: return "R6";
         4'd6: return "R7";
         4'd7: return "R8";
         4'd8, 4'd9, 4'd10, 4'd11, 4'd12: return "R9";
         4'd13, 4'd14: return "R11";
         default: return "R12";
      endcase
   endfunction

   task automatic run(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b, input logic f);
      logic [67:0] e;
      string t;
      @(negedge clk);
      in_valid_i = 1'b1; op_i = op; src0_i = a; src1_i = b; flag_i = f;
      e = model(op, a, b, f);
      t = tag_of(op);
      @(negedge clk);
      in_valid_i = 1'b0;
      chk(t, "result", res_o, e[63:0]);
      chk((op >= 4'd8 && op <= 4'd12) ? "R10" : t, "flag", {63'd0, flag_o}, {63'd0, e[64]});
      chk((op == 4'd15) ? "R12" : "R1", "valid/wide/illegal",
          {61'd0, illegal_o, res_valid_o, res_wide_o}, {61'd0, e[67], e[66], e[65]});
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      // R14: reset state
      flag_i = 1'b1; in_valid_i = 1'b1; op_i = 4'd7; src0_i = '1; src1_i = 64'h1F;
      repeat (3) @(negedge clk);
      chk("R14", "reset outputs", {res_o[63:4], res_o[3:0] | {res_valid_o, res_wide_o, flag_o, illegal_o}}, 64'd0);
      chk("R14", "reset result", res_o, 64'd0);
      in_valid_i = 1'b0;
      rst_n = 1'b1;
      // R13: idle cycle passes the flag through
      @(negedge clk);
      flag_i = 1'b1; src0_i = '1;
      @(negedge clk);
      chk("R13", "idle flag", {63'd0, flag_o}, 64'd1);
      chk("R13", "idle valid", {62'd0, res_valid_o, illegal_o}, 64'd0);
      chk("R13", "idle result", res_o, 64'd0);
      flag_i = 1'b0;
      @(negedge clk);
      chk("R13", "idle flag low", {63'd0, flag_o}, 64'd0);

      // all opcodes, both flags, operand pattern grid
      for (int op = 0; op < 16; op++)
         for (int f = 0; f < 2; f++)
            for (int i = 0; i < 12; i++)
               for (int j = 0; j < 12; j++)
                  run(4'(op), pat(i), pat(j), f[0]);

      // R4 corner: carry produced by the incoming flag alone
      run(4'd2, 64'hFFFF_FFFE, 64'h1, 1'b1);

      // R8: offset x width sweep with field running past bit 31
      for (int off = 0; off < 32; off++)
         for (int wd = 0; wd < 48; wd++)
            run(4'd7, 64'hFFFF_0000_A5C3_96E1, {32'hFFFF_FFFF, 9'h1FF, 7'(wd), 11'h7E0, 5'(off)}, off[0]);

      // R12: illegal opcode pulse lasts one cycle
      run(4'd15, '1, '1, 1'b1);
      @(negedge clk);
      chk("R12", "illegal pulse width", {63'd0, illegal_o}, 64'd0);

      finish_up();
   end

endmodule